// File: doc/BRIEF.md
# Dual Frequency Reference Checker

This block watches two nominal 10 MHz reference signals, one from the board's own oscillator and one from an outside source. It reports whether each is present and close to its expected frequency. A measurement window is timed by the block's local clock, and its length in local clock cycles is set by software. Across each window the block counts the rising edges of both references in parallel. When the window closes, both counts are latched where software can read them. Each count is judged against a software-set pair of exclusive limits, and the next window starts on the following cycle, with no trigger needed.

Each reference passes through its own synchroniser before its edges are detected, so the two inputs may be fully asynchronous to the local clock. The result of each channel is a single good/bad bit. A change in either bit raises a sticky pending flag. That flag drives the interrupt output when software has enabled it. The block ignores the very first window after reset when it looks for changes, so reset values never raise a spurious interrupt.

Register map (3-bit address, DW-bit data): 0 window length; 1 internal lower limit; 2 internal upper limit; 3 external lower limit; 4 external upper limit; 5 internal latched count (read only); 6 external latched count (read only); 7 control/status, with bit 0 internal good, bit 1 external good, bit 2 change pending and bit 3 interrupt enable.

Top module: `freq_ref_checker`

## Requirements
- R1: A window lasts exactly the number of local clock cycles held in register 0 (values below 2 act as 2), and every local cycle falls in exactly one window. A reference with a period of P local cycles therefore yields exactly W/P edges in a window of W cycles when P divides W.
- R2: At the close of every window, both edge counts are copied to registers 5 and 6 and the running counters restart from zero. Windows follow one another with no software action.
- R3: Status bit 0 (internal) and bit 1 (external) of register 7 read 1 only when that channel's latched count is strictly greater than its lower limit and strictly less than its upper limit. A count equal to either limit reads 0.
- R4: A reference that stays static gives a latched count of 0 and so a bad status bit whenever its lower limit is 0 or more.
- R5: After reset, register 0 holds the DEF_WIN parameter (100 by default), registers 1 to 7 read 0, and irq_o is low.
- R6: The first window completed after reset never sets the pending bit (register 7 bit 2), whatever status it produces.
- R7: On any later window close where at least one status bit changes value, the pending bit is set. A close that leaves both bits unchanged does not set it.
- R8: The pending bit stays at 1 until a write to register 7 with bit 2 set to 1, and writing 0 there has no effect. The interrupt enable is register 7 bit 3. irq_o is high exactly when both pending and enable are 1.
- R9: A write to register 0 restarts the current window from its first cycle and discards the partial counts, while the latched counts keep their previous values until the new window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_int_i | input | 1 | Internally generated reference, asynchronous |
| ref_ext_i | input | 1 | External reference, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address for read and write |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Status-change interrupt, level |

## Verification
If the window timer loses or gains a cycle, the latched counts drift from the exact W/P values, and this shows on the count registers at the next window close. A wrong limit comparison or status register appears in register 7 within one window of the limits being set. Faults in the pending logic show on irq_o one window after a reference is stopped or restarted, or at once when software writes a clear or the enable. A faulty restart shows within one window length of a write to register 0, because the counts either update early or hold stale values.

// File: rtl/frc_pkg.sv
package frc_pkg;
   localparam int unsigned NCH      = 2;
   localparam int unsigned CH_INT   = 0;
   localparam int unsigned CH_EXT   = 1;
   localparam int unsigned AW       = 3;

   localparam logic [AW-1:0] A_WIN   = 3'd0;
   localparam logic [AW-1:0] A_LO_I  = 3'd1;
   localparam logic [AW-1:0] A_HI_I  = 3'd2;
   localparam logic [AW-1:0] A_LO_E  = 3'd3;
   localparam logic [AW-1:0] A_HI_E  = 3'd4;
   localparam logic [AW-1:0] A_CNT_I = 3'd5;
   localparam logic [AW-1:0] A_CNT_E = 3'd6;
   localparam logic [AW-1:0] A_STAT  = 3'd7;

   localparam int unsigned SB_GOOD_I = 0;
   localparam int unsigned SB_GOOD_E = 1;
   localparam int unsigned SB_PEND   = 2;
   localparam int unsigned SB_EN     = 3;
   localparam int unsigned SB_COUNT  = 4;

   localparam int unsigned MIN_WIN   = 2;
endpackage

// File: rtl/frc_sync_edge.sv
module frc_sync_edge #(
   parameter int unsigned STAGES     = 2,
   parameter bit          BOTH_EDGES = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic pulse_o
);
   logic [STAGES-1:0] sh_q;
   logic              prev_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("frc_sync_edge: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         prev_q <= 1'b0;
      end else begin
         sh_q   <= {sh_q[STAGES-2:0], async_i};
         prev_q <= sh_q[STAGES-1];
      end
   end

   if (BOTH_EDGES) begin : g_both
      assign pulse_o = sh_q[STAGES-1] ^ prev_q;
   end else begin : g_rise
      assign pulse_o = sh_q[STAGES-1] & ~prev_q;
   end
endmodule

// File: rtl/frc_window_timer.sv
module frc_window_timer #(
   parameter int unsigned DW      = 16,
   parameter int unsigned MIN_WIN = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart_i,
   input  logic [DW-1:0] win_len_i,
   output logic          end_o,
   output logic [DW-1:0] tcnt_o
);
   localparam logic [DW-1:0] MIN_W = DW'(MIN_WIN);

   logic [DW-1:0] win_eff;
   logic [DW-1:0] tcnt_q;
   logic          last;

   if (MIN_WIN < 2) begin : g_bad_min
      $error("frc_window_timer: MIN_WIN must be at least 2");
   end

   assign win_eff = (win_len_i < MIN_W) ? MIN_W : win_len_i;
   assign last    = (tcnt_q >= win_eff - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tcnt_q <= '0;
      end else if (restart_i || last) begin
         tcnt_q <= '0;
      end else begin
         tcnt_q <= tcnt_q + 1'b1;
      end
   end

   assign end_o  = last && !restart_i;
   assign tcnt_o = tcnt_q;
endmodule

// File: rtl/frc_chan.sv
module frc_chan #(
   parameter int unsigned DW         = 16,
   parameter int unsigned STAGES     = 2,
   parameter bit          BOTH_EDGES = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ref_i,
   input  logic          restart_i,
   input  logic          win_end_i,
   input  logic [DW-1:0] lo_i,
   input  logic [DW-1:0] hi_i,
   output logic [DW-1:0] run_o,
   output logic [DW-1:0] cnt_o,
   output logic          good_o,
   output logic          good_nxt_o
);
   logic          pulse;
   logic [DW-1:0] run_q;
   logic [DW-1:0] cnt_q;
   logic          good_q;
   logic [DW-1:0] total;

   frc_sync_edge #(
      .STAGES     (STAGES),
      .BOTH_EDGES (BOTH_EDGES)
   ) sync_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (ref_i),
      .pulse_o (pulse)
   );

   assign total      = run_q + {{(DW-1){1'b0}}, pulse};
   assign good_nxt_o = (total > lo_i) && (total < hi_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= '0;
         cnt_q  <= '0;
         good_q <= 1'b0;
      end else if (restart_i) begin
         run_q  <= '0;
      end else if (win_end_i) begin
         cnt_q  <= total;
         good_q <= good_nxt_o;
         run_q  <= '0;
      end else begin
         run_q  <= total;
      end
   end

   assign run_o  = run_q;
   assign cnt_o  = cnt_q;
   assign good_o = good_q;
endmodule

// File: rtl/freq_ref_checker.sv
module freq_ref_checker #(
   parameter int unsigned DW         = 16,
   parameter int unsigned DEF_WIN    = 100,
   parameter int unsigned STAGES     = 2,
   parameter bit          BOTH_EDGES = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ref_int_i,
   input  logic                     ref_ext_i,
   input  logic                     reg_wr_i,
   input  logic [frc_pkg::AW-1:0]   reg_addr_i,
   input  logic [DW-1:0]            reg_wdata_i,
   output logic [DW-1:0]            reg_rdata_o,
   output logic                     irq_o
);
   import frc_pkg::*;

   if (DW < 8) begin : g_bad_dw
      $error("freq_ref_checker: DW must be at least 8");
   end
   if (DEF_WIN >= (64'd1 << DW)) begin : g_bad_def
      $error("freq_ref_checker: DEF_WIN does not fit in DW bits");
   end

   logic [DW-1:0]  win_q;
   logic [DW-1:0]  lo_q   [NCH];
   logic [DW-1:0]  hi_q   [NCH];
   logic [DW-1:0]  run_w  [NCH];
   logic [DW-1:0]  cnt_w  [NCH];
   logic [NCH-1:0] good_w;
   logic [NCH-1:0] good_nxt_w;
   logic           pend_q;
   logic           en_q;
   logic           first_done_q;
   logic           win_end;
   logic           restart;
   logic [DW-1:0]  tmr_cnt;
   logic           pend_set;
   logic           pend_clr;
   logic           wr_stat;

   assign restart  = reg_wr_i && (reg_addr_i == A_WIN);
   assign wr_stat  = reg_wr_i && (reg_addr_i == A_STAT);
   assign pend_clr = wr_stat && reg_wdata_i[SB_PEND];
   assign pend_set = win_end && first_done_q && (good_nxt_w != good_w);

   frc_window_timer #(
      .DW      (DW),
      .MIN_WIN (MIN_WIN)
   ) timer_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (restart),
      .win_len_i (win_q),
      .end_o     (win_end),
      .tcnt_o    (tmr_cnt)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic ref_sel;
      if (c == CH_INT) begin : g_int
         assign ref_sel = ref_int_i;
      end else begin : g_ext
         assign ref_sel = ref_ext_i;
      end

      frc_chan #(
         .DW         (DW),
         .STAGES     (STAGES),
         .BOTH_EDGES (BOTH_EDGES)
      ) chan_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .ref_i      (ref_sel),
         .restart_i  (restart),
         .win_end_i  (win_end),
         .lo_i       (lo_q[c]),
         .hi_i       (hi_q[c]),
         .run_o      (run_w[c]),
         .cnt_o      (cnt_w[c]),
         .good_o     (good_w[c]),
         .good_nxt_o (good_nxt_w[c])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo_q[c] <= '0;
            hi_q[c] <= '0;
         end else if (reg_wr_i) begin
            if (reg_addr_i == AW'(1 + 2*c)) lo_q[c] <= reg_wdata_i;
            if (reg_addr_i == AW'(2 + 2*c)) hi_q[c] <= reg_wdata_i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q        <= DW'(DEF_WIN);
         en_q         <= 1'b0;
         pend_q       <= 1'b0;
         first_done_q <= 1'b0;
      end else begin
         if (restart) win_q <= reg_wdata_i;
         if (wr_stat) en_q  <= reg_wdata_i[SB_EN];
         if (win_end) first_done_q <= 1'b1;
         if (pend_set)      pend_q <= 1'b1;
         else if (pend_clr) pend_q <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata_o = '0;
      case (reg_addr_i)
         A_WIN:   reg_rdata_o = win_q;
         A_LO_I:  reg_rdata_o = lo_q[CH_INT];
         A_HI_I:  reg_rdata_o = hi_q[CH_INT];
         A_LO_E:  reg_rdata_o = lo_q[CH_EXT];
         A_HI_E:  reg_rdata_o = hi_q[CH_EXT];
         A_CNT_I: reg_rdata_o = cnt_w[CH_INT];
         A_CNT_E: reg_rdata_o = cnt_w[CH_EXT];
         default: begin
            reg_rdata_o[SB_GOOD_I] = good_w[CH_INT];
            reg_rdata_o[SB_GOOD_E] = good_w[CH_EXT];
            reg_rdata_o[SB_PEND]   = pend_q;
            reg_rdata_o[SB_EN]     = en_q;
         end
      endcase
   end

   assign irq_o = pend_q & en_q;
endmodule

// File: rtl/freq_ref_checker_chk.sv
module freq_ref_checker_chk #(
   parameter int unsigned DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_wr_i,
   input logic [2:0]    reg_addr_i,
   input logic [DW-1:0] reg_wdata_i,
   input logic          win_end,
   input logic [DW-1:0] tmr_cnt,
   input logic [DW-1:0] win_q,
   input logic [DW-1:0] run_int,
   input logic [DW-1:0] run_ext,
   input logic [DW-1:0] cnt_int,
   input logic [DW-1:0] lo_int,
   input logic [DW-1:0] hi_int,
   input logic [1:0]    good_w,
   input logic [1:0]    good_nxt_w,
   input logic          pend_q,
   input logic          first_done_q
);
   // R1
   win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_cnt < win_q) || (win_q < 2 && tmr_cnt < 2));

   // R2
   run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_end |=> (run_int == '0 && run_ext == '0));

   // R3
   good_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_end && !reg_wr_i) |=> (good_w[0] == ((cnt_int > lo_int) && (cnt_int < hi_int))));

   // R6
   first_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_end && !first_done_q && !pend_q) |=> !pend_q);

   // R7
   steady_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_end && (good_nxt_w == good_w) && !pend_q) |=> !pend_q);

   // R7
   change_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_end && first_done_q && (good_nxt_w != good_w)) |=> pend_q);

   // R8
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !(reg_wr_i && reg_addr_i == 3'd7 && reg_wdata_i[2])) |=> pend_q);
endmodule

bind freq_ref_checker freq_ref_checker_chk #(.DW(DW)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_wr_i     (reg_wr_i),
   .reg_addr_i   (reg_addr_i),
   .reg_wdata_i  (reg_wdata_i),
   .win_end      (win_end),
   .tmr_cnt      (tmr_cnt),
   .win_q        (win_q),
   .run_int      (run_w[0]),
   .run_ext      (run_w[1]),
   .cnt_int      (cnt_w[0]),
   .lo_int       (lo_q[0]),
   .hi_int       (hi_q[0]),
   .good_w       (good_w),
   .good_nxt_w   (good_nxt_w),
   .pend_q       (pend_q),
   .first_done_q (first_done_q)
);

// File: tb/freq_ref_checker_tb_top.sv
module freq_ref_checker_tb_top;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ref_int = 1'b0;
   logic          ref_ext = 1'b0;
   logic          wr = 1'b0;
   logic [2:0]    addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          irq;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;
   int half_int = 5;
   int half_ext = 4;
   int ph_int = 0;
   int ph_ext = 0;

   always #2 clk = ~clk;

   freq_ref_checker #(.DW(DW)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .ref_int_i   (ref_int),
      .ref_ext_i   (ref_ext),
      .reg_wr_i    (wr),
      .reg_addr_i  (addr),
      .reg_wdata_i (wdata),
      .reg_rdata_o (rdata),
      .irq_o       (irq)
   );

   always @(negedge clk) begin
      if (half_int == 0) begin ref_int <= 1'b0; ph_int <= 0; end
      else if (ph_int >= half_int - 1) begin ref_int <= ~ref_int; ph_int <= 0; end
      else ph_int <= ph_int + 1;
      if (half_ext == 0) begin ref_ext <= 1'b0; ph_ext <= 0; end
      else if (ph_ext >= half_ext - 1) begin ref_ext <= ~ref_ext; ph_ext <= 0; end
      else ph_ext <= ph_ext + 1;
   end

   task automatic chk(input string req, input string what, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] a, input int d);
      @(negedge clk);
      wr = 1'b1; addr = a; wdata = DW'(d);
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output int d);
      @(negedge clk);
      addr = a;
      #1;
      d = int'(rdata);
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      int v;
      rd_reg(3'd0, v); chk("R5", "window reset", v, 100);
      for (int a = 1; a < 8; a++) begin
         rd_reg(3'(a), v); chk("R5", $sformatf("reg %0d reset", a), v, 0);
      end
      chk("R5", "irq reset", int'(irq), 0);
   endtask

   task automatic t_first_window();
      int v;
      wr_reg(3'd1, 0); wr_reg(3'd2, 16'hFFFF);
      wr_reg(3'd3, 0); wr_reg(3'd4, 16'hFFFF);
      wr_reg(3'd7, 8);
      wait_clk(150);
      rd_reg(3'd7, v); chk("R6", "first window no pending", v, 11);
      chk("R6", "first window irq", int'(irq), 0);
      wait_clk(300);
      rd_reg(3'd7, v); chk("R7", "unchanged status no pending", v, 11);
   endtask

   task automatic t_counts();
      int v;
      wr_reg(3'd0, 200);
      wait_clk(450);
      rd_reg(3'd5, v); chk("R1", "int count W200 P10", v, 20);
      rd_reg(3'd6, v); chk("R1", "ext count W200 P8", v, 25);
      wr_reg(3'd0, 400);
      wait_clk(350);
      rd_reg(3'd5, v); chk("R9", "latched held after restart", v, 20);
      wait_clk(100);
      rd_reg(3'd5, v); chk("R9", "int count after restart", v, 40);
      rd_reg(3'd6, v); chk("R1", "ext count W400", v, 50);
      half_int = 8;
      wait_clk(900);
      rd_reg(3'd5, v); chk("R2", "int count repeats P16", v, 25);
      half_int = 5;
      wr_reg(3'd0, 200);
      wait_clk(450);
      rd_reg(3'd5, v); chk("R2", "int count back to 20", v, 20);
      rd_reg(3'd7, v); chk("R7", "wide limits no pending", v, 11);
   endtask

   task automatic t_limits();
      int v;
      wr_reg(3'd1, 19); wr_reg(3'd2, 21); wait_clk(250);
      rd_reg(3'd7, v); chk("R3", "19<20<21 good", v & 1, 1);
      wr_reg(3'd1, 20); wait_clk(250);
      rd_reg(3'd7, v); chk("R3", "count equals lower bad", v & 1, 0);
      wr_reg(3'd1, 19); wr_reg(3'd2, 20); wait_clk(250);
      rd_reg(3'd7, v); chk("R3", "count equals upper bad", v & 1, 0);
      wr_reg(3'd2, 21); wait_clk(250);
      rd_reg(3'd7, v); chk("R3", "back to good", v & 1, 1);
      wr_reg(3'd3, 24); wr_reg(3'd4, 26); wait_clk(250);
      rd_reg(3'd7, v); chk("R3", "ext 24<25<26 good", (v >> 1) & 1, 1);
      wr_reg(3'd4, 25); wait_clk(250);
      rd_reg(3'd7, v); chk("R3", "ext equals upper bad", (v >> 1) & 1, 0);
      wr_reg(3'd1, 0); wr_reg(3'd2, 16'hFFFF);
      wr_reg(3'd3, 0); wr_reg(3'd4, 16'hFFFF);
      wait_clk(250);
      wr_reg(3'd7, 12);
      wait_clk(10);
      rd_reg(3'd7, v); chk("R8", "cleared after limits test", v, 11);
   endtask

   task automatic t_irq_flow();
      int v;
      half_ext = 0;
      wait_clk(650);
      rd_reg(3'd6, v); chk("R4", "missing ref count", v, 0);
      rd_reg(3'd7, v); chk("R4", "missing ref bad", (v >> 1) & 1, 0);
      chk("R7", "pending on change", (v >> 2) & 1, 1);
      chk("R8", "irq on pending+enable", int'(irq), 1);
      wr_reg(3'd7, 8);
      rd_reg(3'd7, v); chk("R8", "write 0 keeps pending", (v >> 2) & 1, 1);
      wr_reg(3'd7, 12);
      chk("R8", "irq low after clear", int'(irq), 0);
      wait_clk(450);
      rd_reg(3'd7, v); chk("R7", "steady bad no pending", (v >> 2) & 1, 0);
      wr_reg(3'd7, 0);
      half_ext = 4;
      wait_clk(650);
      rd_reg(3'd7, v); chk("R7", "ext recovered sets pending", v, 7);
      chk("R8", "irq gated by enable", int'(irq), 0);
      wr_reg(3'd7, 8);
      wait_clk(1);
      chk("R8", "irq on enable", int'(irq), 1);
      wr_reg(3'd7, 12);
      wait_clk(1);
      chk("R8", "irq cleared", int'(irq), 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_first_window();
      t_counts();
      t_limits();
      t_irq_flow();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule